// File: doc/BRIEF.md
# Interrupt control bus-cycle sequencer

This block sits in a CPU bus interface and issues the special read cycles that go with interrupts. When the core accepts a non-maskable or maskable interrupt, the block runs one or two single-byte reads. When the core executes a return from a vectored interrupt, it runs the matching end-of-interrupt reads. Only the code on the four status pins sets these cycles apart from ordinary transfers. The block returns the byte it reads, which is either a vector or a cascade index, to the core on a one-cycle `done_o` pulse.

A vectored acknowledge can come back with a cascade index, meaning a byte from 0xF0 to 0xFF, i.e. -16 to -1. In that case the block asks the core for the address of the secondary interrupt controller. Once the core supplies it, the block runs a second cycle at that address. The lowest address bit picks the byte lane, which decides both the high-byte enable and which half of the data bus holds the vector. Cascaded returns follow the same two-stage pattern, but with their own status codes. The block remembers the kind of the last acknowledge, so a return after a non-maskable or non-vectored interrupt issues no bus cycle.

Top module: `irq_cycle_seq`

## Requirements
- R1: After reset, and while idle, `bus_req_o`, `done_o` and `casc_req_o` are low, `ddin_n_o` and `hbe_n_o` are high, and `status_o` is 4'b0000.
- R2: An acknowledge with `ack_kind_i` = 2'b00 (non-maskable) runs one read at address 0xFFFF00 with status 4'b0100. It ends with `done_o`, `vector_o` = data bits 7:0 and `cascaded_o` = 0.
- R3: Every first-stage cycle drives `ddin_n_o` low, `hbe_n_o` high and address bit 0 low, and takes the byte from data bits 7:0. An acknowledge with `ack_kind_i` = 2'b01 (non-vectored) or 2'b1x (vectored) reads at 0xFFFE00 with status 4'b0100.
- R4: A bus cycle lasts until `bus_rdy_i` is high at a clock edge. While it waits, the address, status and byte enable hold steady.
- R5: Only for vectored kinds, a first-stage byte in 0xF0..0xFF raises `casc_req_o` with that byte on `casc_idx_o`. No bus cycle starts until `casc_addr_vld_i` is high. A non-vectored acknowledge treats such a byte as plain data.
- R6: The cascaded acknowledge's second cycle uses status 4'b0101 at `casc_addr_i`. For an even address, `hbe_n_o` is high and the vector comes from bits 7:0. For an odd address, `hbe_n_o` is low and the vector comes from bits 15:8. The sequence ends with `cascaded_o` = 1.
- R7: A return after a vectored acknowledge runs a read at 0xFFFE00 with status 4'b0110. With a non-cascade byte, it ends with `vector_o` = that byte and `cascaded_o` = 0.
- R8: A return after a non-maskable or non-vectored acknowledge runs no bus cycle. It pulses `done_o` one cycle after acceptance and leaves `vector_o` and `cascaded_o` unchanged.
- R9: A cascaded return runs a second cycle with status 4'b0111 at the cascade address, using the R6 lane rule. The data read in that cycle is ignored: `vector_o` returns the cascade index and `cascaded_o` = 1.
- R10: Requests are levels and are taken only while idle. A request raised mid-sequence starts after `done_o`. When both are pending in idle, the acknowledge wins.
- R11: `done_o` is a one-cycle pulse with no bus cycle and no cascade request in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ack_req_i | input | 1 | Interrupt acknowledge request (level) |
| ack_kind_i | input | 2 | 00 non-maskable, 01 non-vectored, 1x vectored |
| ret_req_i | input | 1 | Return-from-interrupt request (level) |
| bus_req_o | output | 1 | Interrupt-control bus cycle in progress |
| addr_o | output | ADDR_W | Cycle address |
| status_o | output | 4 | Cycle status code |
| ddin_n_o | output | 1 | Data direction, low for read |
| hbe_n_o | output | 1 | High byte enable, active low |
| bus_rdy_i | input | 1 | Cycle completes at this edge |
| bus_data_i | input | DATA_W | Read data |
| casc_req_o | output | 1 | Cascade address requested |
| casc_idx_o | output | BYTE_W | Cascade index read in first stage |
| casc_addr_vld_i | input | 1 | Cascade address valid |
| casc_addr_i | input | ADDR_W | Secondary controller address |
| done_o | output | 1 | Sequence complete pulse |
| vector_o | output | BYTE_W | Vector or cascade index returned |
| cascaded_o | output | 1 | Last sequence used the cascade path |

## Verification
The bench builds the block with its defaults: a 24-bit address, a 16-bit data bus and an 8-bit byte. This gives two byte lanes, so both parities of the cascade address are exercised, and it puts the fixed addresses 0xFFFF00 and 0xFFFE00 on the pins. Every bus cycle is first left waiting for one clock, so the steady-output rule is checked on each cycle. Indices 0xF0 and 0xFF and the non-cascade byte 0xEF probe the edges of the cascade range.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_WAIT_ADDR,
    ST_SECOND
  } seq_state_e;

  localparam logic [1:0] KIND_NMI    = 2'b00;
  localparam logic [3:0] STAT_IDLE   = 4'b0000;
  localparam logic [3:0] STAT_ACK1   = 4'b0100;
  localparam logic [3:0] STAT_ACK2   = 4'b0101;
  localparam logic [3:0] STAT_RET1   = 4'b0110;
  localparam logic [3:0] STAT_RET2   = 4'b0111;
endpackage

// File: rtl/irq_seq_lane.sv
module irq_seq_lane #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              a0_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              hbe_n_o
);
  localparam int LANES = DATA_W / BYTE_W;

  generate
    if (LANES >= 2) begin : g_two_lane
      assign byte_o  = a0_i ? data_i[2*BYTE_W-1:BYTE_W] : data_i[BYTE_W-1:0];
      assign hbe_n_o = ~a0_i;
    end else begin : g_one_lane
      logic unused_a0;
      assign unused_a0 = a0_i;
      assign byte_o    = data_i[BYTE_W-1:0];
      assign hbe_n_o   = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_req_i,
  input  logic [1:0]        ack_kind_i,
  input  logic              ret_req_i,
  input  logic              bus_rdy_i,
  input  logic [BYTE_W-1:0] low_byte_i,
  input  logic [BYTE_W-1:0] lane_byte_i,
  input  logic              casc_addr_vld_i,
  input  logic [ADDR_W-1:0] casc_addr_i,
  output seq_state_e        state_o,
  output logic              is_ret_o,
  output logic              is_nmi_o,
  output logic [ADDR_W-1:0] casc_addr_o,
  output logic [BYTE_W-1:0] casc_idx_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] vector_o,
  output logic              cascaded_o
);
  localparam int IDX_LSB = 4;

  seq_state_e        state_q;
  logic              is_ret_q, is_nmi_q, is_vec_q, last_vec_q, done_q, casc_q;
  logic [ADDR_W-1:0] caddr_q;
  logic [BYTE_W-1:0] idx_q, vec_q;
  logic              casc_hit;

  assign casc_hit = &low_byte_i[BYTE_W-1:IDX_LSB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      is_ret_q   <= 1'b0;
      is_nmi_q   <= 1'b0;
      is_vec_q   <= 1'b0;
      last_vec_q <= 1'b0;
      done_q     <= 1'b0;
      casc_q     <= 1'b0;
      caddr_q    <= '0;
      idx_q      <= '0;
      vec_q      <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (ack_req_i) begin
            state_q  <= ST_FIRST;
            is_ret_q <= 1'b0;
            is_nmi_q <= (ack_kind_i == KIND_NMI);
            is_vec_q <= ack_kind_i[1];
          end else if (ret_req_i) begin
            if (last_vec_q) begin
              state_q  <= ST_FIRST;
              is_ret_q <= 1'b1;
              is_nmi_q <= 1'b0;
              is_vec_q <= 1'b1;
            end else begin
              done_q <= 1'b1;  // return handled by trap return, no cycle
            end
          end
        end
        ST_FIRST: begin
          if (bus_rdy_i) begin
            if (is_vec_q && casc_hit) begin
              idx_q   <= low_byte_i;
              state_q <= ST_WAIT_ADDR;
            end else begin
              vec_q   <= low_byte_i;
              casc_q  <= 1'b0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
              if (!is_ret_q) last_vec_q <= is_vec_q;
            end
          end
        end
        ST_WAIT_ADDR: begin
          if (casc_addr_vld_i) begin
            caddr_q <= casc_addr_i;
            state_q <= ST_SECOND;
          end
        end
        ST_SECOND: begin
          if (bus_rdy_i) begin
            vec_q   <= is_ret_q ? idx_q : lane_byte_i;
            casc_q  <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
            if (!is_ret_q) last_vec_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o     = state_q;
  assign is_ret_o    = is_ret_q;
  assign is_nmi_o    = is_nmi_q;
  assign casc_addr_o = caddr_q;
  assign casc_idx_o  = idx_q;
  assign done_o      = done_q;
  assign vector_o    = vec_q;
  assign cascaded_o  = casc_q;

  assert_no_cycle_ret_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !ack_req_i && ret_req_i && !last_vec_q) |=> (state_q == ST_IDLE && done_q));

  assert_wait_addr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_ADDR && !casc_addr_vld_i) |=> (state_q == ST_WAIT_ADDR));

  assert_busy_no_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FIRST && !bus_rdy_i) |=> ($stable(is_ret_q) && $stable(is_nmi_q)));
endmodule

// File: rtl/irq_seq_drv.sv
module irq_seq_drv
  import irq_seq_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] NMI_ADDR = 24'hFFFF00,
  parameter logic [ADDR_W-1:0] ICU_ADDR = 24'hFFFE00
) (
  input  seq_state_e        state_i,
  input  logic              is_ret_i,
  input  logic              is_nmi_i,
  input  logic [ADDR_W-1:0] casc_addr_i,
  input  logic              lane_hbe_n_i,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [3:0]        status_o,
  output logic              ddin_n_o,
  output logic              hbe_n_o,
  output logic              casc_req_o
);
  always_comb begin
    bus_req_o  = 1'b0;
    addr_o     = '0;
    status_o   = STAT_IDLE;
    ddin_n_o   = 1'b1;
    hbe_n_o    = 1'b1;
    casc_req_o = 1'b0;
    case (state_i)
      ST_FIRST: begin
        bus_req_o = 1'b1;
        addr_o    = is_nmi_i ? NMI_ADDR : ICU_ADDR;
        status_o  = is_ret_i ? STAT_RET1 : STAT_ACK1;
        ddin_n_o  = 1'b0;
      end
      ST_WAIT_ADDR: casc_req_o = 1'b1;
      ST_SECOND: begin
        bus_req_o = 1'b1;
        addr_o    = casc_addr_i;
        status_o  = is_ret_i ? STAT_RET2 : STAT_ACK2;
        ddin_n_o  = 1'b0;
        hbe_n_o   = lane_hbe_n_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_cycle_seq.sv
module irq_cycle_seq
  import irq_seq_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter int                DATA_W   = 16,
  parameter int                BYTE_W   = 8,
  parameter logic [ADDR_W-1:0] NMI_ADDR = 24'hFFFF00,
  parameter logic [ADDR_W-1:0] ICU_ADDR = 24'hFFFE00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_req_i,
  input  logic [1:0]        ack_kind_i,
  input  logic              ret_req_i,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [3:0]        status_o,
  output logic              ddin_n_o,
  output logic              hbe_n_o,
  input  logic              bus_rdy_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              casc_req_o,
  output logic [BYTE_W-1:0] casc_idx_o,
  input  logic              casc_addr_vld_i,
  input  logic [ADDR_W-1:0] casc_addr_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] vector_o,
  output logic              cascaded_o
);
  seq_state_e        state;
  logic              is_ret, is_nmi, lane_hbe_n;
  logic [ADDR_W-1:0] caddr;
  logic [BYTE_W-1:0] lane_byte;

  irq_seq_lane #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_lane (
    .a0_i   (caddr[0]),
    .data_i (bus_data_i),
    .byte_o (lane_byte),
    .hbe_n_o(lane_hbe_n)
  );

  irq_seq_fsm #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ack_req_i      (ack_req_i),
    .ack_kind_i     (ack_kind_i),
    .ret_req_i      (ret_req_i),
    .bus_rdy_i      (bus_rdy_i),
    .low_byte_i     (bus_data_i[BYTE_W-1:0]),
    .lane_byte_i    (lane_byte),
    .casc_addr_vld_i(casc_addr_vld_i),
    .casc_addr_i    (casc_addr_i),
    .state_o        (state),
    .is_ret_o       (is_ret),
    .is_nmi_o       (is_nmi),
    .casc_addr_o    (caddr),
    .casc_idx_o     (casc_idx_o),
    .done_o         (done_o),
    .vector_o       (vector_o),
    .cascaded_o     (cascaded_o)
  );

  irq_seq_drv #(.ADDR_W(ADDR_W), .NMI_ADDR(NMI_ADDR), .ICU_ADDR(ICU_ADDR)) u_drv (
    .state_i     (state),
    .is_ret_i    (is_ret),
    .is_nmi_i    (is_nmi),
    .casc_addr_i (caddr),
    .lane_hbe_n_i(lane_hbe_n),
    .bus_req_o   (bus_req_o),
    .addr_o      (addr_o),
    .status_o    (status_o),
    .ddin_n_o    (ddin_n_o),
    .hbe_n_o     (hbe_n_o),
    .casc_req_o  (casc_req_o)
  );

  assert_status_group_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (status_o[3:2] == 2'b01 && !ddin_n_o));

  assert_first_lane_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && (status_o == STAT_ACK1 || status_o == STAT_RET1)) |-> (hbe_n_o && !addr_o[0]));

  assert_cycle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_rdy_i) |=> (bus_req_o && $stable(addr_o) && $stable(status_o) && $stable(hbe_n_o)));

  assert_casc_quiet_bus_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_req_o |-> !bus_req_o);

  assert_second_lane_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && (status_o == STAT_ACK2 || status_o == STAT_RET2)) |-> (hbe_n_o == !addr_o[0]));

  assert_done_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!bus_req_o && !casc_req_o));
endmodule

// File: tb/irq_cycle_seq_tb_top.sv
module irq_cycle_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ack_req = 1'b0, ret_req = 1'b0, bus_rdy = 1'b0, casc_vld = 1'b0;
  logic [1:0]  ack_kind = 2'b00;
  logic [15:0] bus_data = '0;
  logic [23:0] casc_addr = '0;
  logic        bus_req, ddin_n, hbe_n, casc_req, done, cascaded;
  logic [23:0] addr;
  logic [3:0]  status;
  logic [7:0]  casc_idx, vector;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  irq_cycle_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ack_req_i(ack_req), .ack_kind_i(ack_kind), .ret_req_i(ret_req),
    .bus_req_o(bus_req), .addr_o(addr), .status_o(status),
    .ddin_n_o(ddin_n), .hbe_n_o(hbe_n),
    .bus_rdy_i(bus_rdy), .bus_data_i(bus_data),
    .casc_req_o(casc_req), .casc_idx_o(casc_idx),
    .casc_addr_vld_i(casc_vld), .casc_addr_i(casc_addr),
    .done_o(done), .vector_o(vector), .cascaded_o(cascaded)
  );

  typedef struct packed {
    logic        ret;
    logic [1:0]  kind;
    logic [15:0] d1;
    logic [23:0] ca;
    logic [15:0] d2;
    logic [1:0]  ncyc;
    logic [7:0]  ev;
    logic        ec;
  } vec_t;

  localparam int N_VEC = 14;
  localparam vec_t VECS [N_VEC] = '{
    '{1'b0, 2'd0, 16'h55AA, 24'h0,      16'h0,    2'd1, 8'hAA, 1'b0}, // R2 nmi
    '{1'b1, 2'd0, 16'h0,    24'h0,      16'h0,    2'd0, 8'hAA, 1'b0}, // R8
    '{1'b0, 2'd1, 16'h0011, 24'h0,      16'h0,    2'd1, 8'h11, 1'b0}, // R3 nonvec
    '{1'b1, 2'd0, 16'h0,    24'h0,      16'h0,    2'd0, 8'h11, 1'b0}, // R8
    '{1'b0, 2'd2, 16'h1234, 24'h0,      16'h0,    2'd1, 8'h34, 1'b0}, // R3 vec
    '{1'b1, 2'd0, 16'h0034, 24'h0,      16'h0,    2'd1, 8'h34, 1'b0}, // R7
    '{1'b0, 2'd2, 16'h00F3, 24'h001230, 16'hAB5C, 2'd2, 8'h5C, 1'b1}, // R6 even
    '{1'b1, 2'd0, 16'h00F3, 24'h001230, 16'h9999, 2'd2, 8'hF3, 1'b1}, // R9
    '{1'b0, 2'd3, 16'h00FF, 24'h004567, 16'hC812, 2'd2, 8'hC8, 1'b1}, // R6 odd
    '{1'b1, 2'd0, 16'h00FF, 24'h004567, 16'h1111, 2'd2, 8'hFF, 1'b1}, // R9 odd
    '{1'b0, 2'd2, 16'h00EF, 24'h0,      16'h0,    2'd1, 8'hEF, 1'b0}, // R5 edge
    '{1'b0, 2'd2, 16'h00F0, 24'h000102, 16'h0080, 2'd2, 8'h80, 1'b1}, // R5 edge
    '{1'b0, 2'd1, 16'h00F5, 24'h0,      16'h0,    2'd1, 8'hF5, 1'b0}, // R5 nonvec
    '{1'b1, 2'd0, 16'h0,    24'h0,      16'h0,    2'd0, 8'hF5, 1'b0}  // R8
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_seq(input vec_t v, input string req);
    int  cyc = 0;
    int  guard = 0;
    bit  held = 1'b0;
    bit  fin = 1'b0;
    logic [23:0] ea;
    logic [3:0]  es;
    if (v.ret) ret_req = 1'b1;
    else begin ack_req = 1'b1; ack_kind = v.kind; end
    while (!fin && guard < 60) begin
      @(negedge clk);
      guard++;
      bus_rdy  = 1'b0;
      casc_vld = 1'b0;
      if (done) begin
        fin = 1'b1;
        ack_req = 1'b0;
        ret_req = 1'b0;
        check(vector == v.ev, req, "vector", vector, v.ev);
        check(cascaded == v.ec, req, "cascaded", cascaded, v.ec);
        check(cyc == v.ncyc, req, "cycle count", cyc, v.ncyc);
      end else if (casc_req) begin
        check(casc_idx == v.d1[7:0], "R5", "cascade index", casc_idx, v.d1[7:0]);
        casc_addr = v.ca;
        casc_vld  = 1'b1;
      end else if (bus_req) begin
        if (cyc == 0) begin
          ea = (!v.ret && v.kind == 2'd0) ? 24'hFFFF00 : 24'hFFFE00;
          es = v.ret ? 4'b0110 : 4'b0100;
        end else begin
          ea = v.ca;
          es = v.ret ? 4'b0111 : 4'b0101;
        end
        check(addr == ea, req, "address", addr, ea);
        check(status == es, req, "status", status, es);
        check(hbe_n == ((cyc == 0) ? 1'b1 : ~v.ca[0]), req, "hbe_n", hbe_n,
              (cyc == 0) ? 1'b1 : ~v.ca[0]);
        check(!ddin_n, "R3", "ddin_n", ddin_n, 0);
        if (!held) held = 1'b1;  // R4: one wait state on every cycle
        else begin
          bus_rdy  = 1'b1;
          bus_data = (cyc == 0) ? v.d1 : v.d2;
          cyc++;
          held = 1'b0;
        end
      end
    end
    check(fin, req, "sequence finished", fin, 1);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!bus_req && !done && !casc_req && ddin_n && hbe_n && status == 4'b0000,
          "R1", "outputs in reset", {bus_req, done, casc_req, ddin_n, hbe_n}, 5'b00011);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!bus_req && !done && !casc_req && ddin_n && status == 4'b0000,
          "R1", "idle after reset", {bus_req, done, casc_req, ddin_n}, 4'b0001);

    for (int i = 0; i < N_VEC; i++) begin
      run_seq(VECS[i], VECS[i].ret ? (VECS[i].ncyc == 0 ? "R8" :
              (VECS[i].ec ? "R9" : "R7")) : (VECS[i].ec ? "R6" : "R2/R3"));
      @(negedge clk);
      check(!done, "R11", "done one cycle", done, 0);
    end

    // R5 cascade wait, R10 held-off return, R6 odd lane
    ack_req = 1'b1; ack_kind = 2'd2;
    @(negedge clk);
    @(negedge clk); bus_rdy = 1'b1; bus_data = 16'h00F1;
    @(negedge clk); bus_rdy = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(casc_req && !bus_req, "R5", "waiting for cascade address", {casc_req, bus_req}, 2'b10);
      @(negedge clk);
    end
    casc_addr = 24'h000A0B; casc_vld = 1'b1;
    @(negedge clk); casc_vld = 1'b0;
    check(bus_req && status == 4'b0101 && !hbe_n, "R6", "odd second cycle", {status, hbe_n}, 5'b01010);
    ret_req = 1'b1;
    bus_rdy = 1'b1; bus_data = 16'h7700;
    @(negedge clk); bus_rdy = 1'b0;
    check(done && vector == 8'h77 && cascaded, "R10", "ack finishes despite return", vector, 8'h77);
    ack_req = 1'b0;
    @(negedge clk);
    check(bus_req && status == 4'b0110, "R10", "held return starts after done", status, 4'b0110);
    run_seq('{1'b1, 2'd0, 16'h00F1, 24'h000A0B, 16'h5555, 2'd2, 8'hF1, 1'b1}, "R9");
    @(negedge clk);

    // R10 priority: acknowledge wins over pending return
    ack_req = 1'b1; ack_kind = 2'd0; ret_req = 1'b1;
    @(negedge clk);
    check(bus_req && status == 4'b0100 && addr == 24'hFFFF00, "R10", "ack priority", status, 4'b0100);
    bus_rdy = 1'b1; bus_data = 16'h0042;
    @(negedge clk); bus_rdy = 1'b0;
    check(done && vector == 8'h42 && !cascaded, "R2", "nmi done", vector, 8'h42);
    ack_req = 1'b0;
    @(negedge clk);
    check(done && !bus_req && vector == 8'h42, "R8", "return after nmi without cycle", {done, bus_req}, 2'b10);
    ret_req = 1'b0;
    @(negedge clk);
    check(!done && !bus_req, "R11", "quiet after return", {done, bus_req}, 2'b00);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule